// File: doc/BRIEF.md
# Fused Boolean Crypto Functional Unit

This block is a 32-bit execution unit for cipher inner loops. One issued operation may mask its first operand with a Boolean step, run a short core operation on the result, and mask that outcome with a second Boolean step. All three steps finish within the issuing clock cycle. The short core operations are a modular add, a left rotate and a read from a byte-indexed substitution table. A separate multiply path is fully pipelined. It accepts one multiply per cycle and returns the low 32 bits of each product a fixed number of cycles later.

The caller drives an opcode and three 32-bit sources together with `in_valid`. Source A feeds the first Boolean step. Source B is the second operand of the core operation. Source C is the mask for both Boolean steps. Results leave on one registered port with a valid flag.

The table has its own write port. Software-visible loading is outside this block. The write port only places words into the table.

The output register is fed from a small result-source selector. Each cycle it sits in one of three states:

- `SRC_NONE`: nothing completes in this cycle.
- `SRC_SHORT`: a short operation issued in this cycle completes.
- `SRC_MUL`: the multiply pipeline's last stage completes.

The selector moves to `SRC_MUL` whenever a multiply reaches the end of the pipe, whatever else is issued. It moves to `SRC_SHORT` when a non-multiply operation is issued and no multiply is finishing. In every other cycle it moves to `SRC_NONE`.

Top module: `cfu_fused_unit`

## Requirements
- R1: While reset is asserted and in every cycle after it until the first issued operation completes, `out_valid` is 0.
- R2: The opcode is decoded by field. `in_op[1:0]` is the pre-op, `in_op[3:2]` is the core op and `in_op[5:4]` is the post-op. Core codes are 0 add, 1 rotate left, 2 multiply and 3 table read. Boolean codes are 0 pass, 1 XOR with `in_c`, 2 AND with `in_c`, and 3 reserved; the reserved code behaves as pass.
- R3: The pre-op is applied to `in_a` before the core operation, and its result replaces A everywhere in that operation.
- R4: The add core returns (pre-op result + `in_b`) modulo 2^32.
- R5: The rotate core rotates the pre-op result left by `in_b[4:0]` and ignores the upper bits of `in_b`. A rotate amount of 0 returns the pre-op result unchanged.
- R6: The post-op is applied to the core result with `in_c` as the mask, for every core operation including multiply.
- R7: An add, rotate or table read issued with `in_valid` high in one cycle appears on `out_data` with `out_valid` high in the next cycle.
- R8: A write with `tbl_wr_en` high stores `tbl_wr_data` at `tbl_wr_idx` on the clock edge. A table read returns the entry selected by bits [7:0] of the pre-op result. A read in the same cycle as a write to the same index returns the previous contents.
- R9: A multiply returns the low 32 bits of (pre-op result × `in_b`), post-op applied, in the third cycle after issue. A multiply may be issued every cycle, and multiply results leave in issue order.
- R10: When a short operation is issued two cycles after a multiply, the multiply result takes the output in the shared completion cycle and the short operation is discarded.
- R11: A cycle with `in_valid` low issues nothing and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 6 | Opcode: pre-op, core op, post-op fields |
| in_a | input | 32 | Source A, input to the pre-op |
| in_b | input | 32 | Source B, second core operand / rotate amount |
| in_c | input | 32 | Source C, mask for both Boolean steps |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 8 | Table write index |
| tbl_wr_data | input | 32 | Table write word |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Result word |

## Verification
The bench sweeps every combination of pre-op, short core and post-op, including the reserved Boolean code, over operand patterns that force add carry-out and wrap. A wrong reserved-code decode or a dropped carry would show up as corrupted words.

Every rotate amount is driven with the upper bits of B set. A design that used the wrong field or mishandled the zero rotate would return a zero or shifted word.

All 256 table entries are read back after loading. A write and a read of the same index are issued in one cycle, and a bypassing table would return the new word too early.

Back-to-back multiplies, a short op slipping ahead of a pending multiply, and a short op issued into the multiply's completion slot expose wrong latency, reordering, or a short result overwriting the product.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    // Boolean step selector, used for both the pre-op and the post-op
    typedef enum logic [1:0] {
        BOOL_PASS = 2'd0,
        BOOL_XOR  = 2'd1,
        BOOL_AND  = 2'd2,
        BOOL_RSVD = 2'd3
    } bool_op_e;

    // Core operation selector
    typedef enum logic [1:0] {
        CORE_ADD  = 2'd0,
        CORE_ROTL = 2'd1,
        CORE_MUL  = 2'd2,
        CORE_TBL  = 2'd3
    } core_op_e;

    // Opcode layout, most significant field first
    typedef struct packed {
        bool_op_e post;
        core_op_e core;
        bool_op_e pre;
    } fu_op_t;

    localparam int FU_OP_W = $bits(fu_op_t);

    // Which source owns the output register in a given cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SHORT = 2'd1,
        SRC_MUL   = 2'd2
    } res_src_e;

endpackage

// File: rtl/cfu_bool_stage.sv
module cfu_bool_stage
    import cfu_pkg::*;
#(
    parameter int W = 32
) (
    input  bool_op_e       op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   mask,
    output logic [W-1:0]   y
);

    always_comb begin
        unique case (op)
            BOOL_XOR:  y = x ^ mask;
            BOOL_AND:  y = x & mask;
            BOOL_PASS: y = x;
            BOOL_RSVD: y = x;   // reserved code acts as pass
            default:   y = x;
        endcase
    end

endmodule

// File: rtl/cfu_subst_table.sv
module cfu_subst_table #(
    parameter int W     = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] entry_q [DEPTH];

    // Write lands on the edge; the combinational read sees the old word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            entry_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/cfu_short_core.sv
module cfu_short_core
    import cfu_pkg::*;
#(
    parameter int W = 32
) (
    input  core_op_e     op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] b,
    input  logic [W-1:0] tbl_word,
    output logic [W-1:0] y
);

    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] rot_amt;
    logic [2*W-1:0]  rot_wide;
    logic [W-1:0]    sum;

    assign rot_amt  = b[SH_W-1:0];
    assign rot_wide = {x, x} << rot_amt;
    assign sum      = x + b;

    always_comb begin
        unique case (op)
            CORE_ADD:  y = sum;
            CORE_ROTL: y = rot_wide[2*W-1:W];
            CORE_TBL:  y = tbl_word;
            CORE_MUL:  y = '0;   // handled by the multiply pipe
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/cfu_mul_pipe.sv
module cfu_mul_pipe
    import cfu_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [W-1:0] x,
    input  logic [W-1:0] b,
    input  logic [W-1:0] mask_in,
    input  bool_op_e     post_in,
    output logic         done,
    output logic [W-1:0] prod,
    output logic [W-1:0] mask_out,
    output bool_op_e     post_out
);

    // The top's output register is the final stage of the latency
    localparam int STAGES = LAT - 1;

    logic [STAGES-1:0] vld_q;
    logic [W-1:0]      prod_q [STAGES];
    logic [W-1:0]      mask_q [STAGES];
    bool_op_e          post_q [STAGES];
    logic [W-1:0]      prod_lo;

    assign prod_lo = x * b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= issue;
            for (int s = 1; s < STAGES; s++) begin
                vld_q[s] <= vld_q[s-1];
            end
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    prod_q[0] <= prod_lo;
                    mask_q[0] <= mask_in;
                    post_q[0] <= post_in;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    prod_q[s] <= prod_q[s-1];
                    mask_q[s] <= mask_q[s-1];
                    post_q[s] <= post_q[s-1];
                end
            end
        end
    endgenerate

    assign done     = vld_q[STAGES-1];
    assign prod     = prod_q[STAGES-1];
    assign mask_out = mask_q[STAGES-1];
    assign post_out = post_q[STAGES-1];

endmodule

// File: rtl/cfu_fused_unit.sv
module cfu_fused_unit
    import cfu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TBL_IDX_W = 8,
    parameter int MUL_LAT   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [FU_OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0]    in_a,
    input  logic [DATA_W-1:0]    in_b,
    input  logic [DATA_W-1:0]    in_c,
    input  logic                 tbl_wr_en,
    input  logic [TBL_IDX_W-1:0] tbl_wr_idx,
    input  logic [DATA_W-1:0]    tbl_wr_data,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data
);

    fu_op_t              op_dec;
    logic [DATA_W-1:0]   pre_res;
    logic [DATA_W-1:0]   tbl_word;
    logic [DATA_W-1:0]   short_res;
    logic                short_fire;
    logic                mul_fire;

    logic                mul_done;
    logic [DATA_W-1:0]   mul_prod;
    logic [DATA_W-1:0]   mul_mask;
    bool_op_e            mul_post;

    res_src_e            src_nxt;
    logic [DATA_W-1:0]   sel_val;
    logic [DATA_W-1:0]   sel_mask;
    bool_op_e            sel_post;
    logic [DATA_W-1:0]   post_res;

    assign op_dec     = fu_op_t'(in_op);
    assign short_fire = in_valid && (op_dec.core != CORE_MUL);
    assign mul_fire   = in_valid && (op_dec.core == CORE_MUL);

    cfu_bool_stage #(.W(DATA_W)) u_pre (
        .op   (op_dec.pre),
        .x    (in_a),
        .mask (in_c),
        .y    (pre_res)
    );

    cfu_subst_table #(.W(DATA_W), .IDX_W(TBL_IDX_W)) u_tbl (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (tbl_wr_data),
        .rd_idx  (pre_res[TBL_IDX_W-1:0]),
        .rd_data (tbl_word)
    );

    cfu_short_core #(.W(DATA_W)) u_core (
        .op       (op_dec.core),
        .x        (pre_res),
        .b        (in_b),
        .tbl_word (tbl_word),
        .y        (short_res)
    );

    cfu_mul_pipe #(.W(DATA_W), .LAT(MUL_LAT)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (mul_fire),
        .x        (pre_res),
        .b        (in_b),
        .mask_in  (in_c),
        .post_in  (op_dec.post),
        .done     (mul_done),
        .prod     (mul_prod),
        .mask_out (mul_mask),
        .post_out (mul_post)
    );

    // Result-source selection: a finishing multiply owns the slot
    always_comb begin
        if (mul_done) begin
            src_nxt = SRC_MUL;
        end else if (short_fire) begin
            src_nxt = SRC_SHORT;
        end else begin
            src_nxt = SRC_NONE;
        end
    end

    always_comb begin
        unique case (src_nxt)
            SRC_MUL: begin
                sel_val  = mul_prod;
                sel_mask = mul_mask;
                sel_post = mul_post;
            end
            SRC_SHORT: begin
                sel_val  = short_res;
                sel_mask = in_c;
                sel_post = op_dec.post;
            end
            default: begin
                sel_val  = '0;
                sel_mask = '0;
                sel_post = BOOL_PASS;
            end
        endcase
    end

    cfu_bool_stage #(.W(DATA_W)) u_post (
        .op   (sel_post),
        .x    (sel_val),
        .mask (sel_mask),
        .y    (post_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= (src_nxt != SRC_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (src_nxt != SRC_NONE) begin
            out_data <= post_res;
        end
    end

endmodule

// File: rtl/cfu_fused_unit_chk.sv
module cfu_fused_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int MUL_LAT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [5:0]        in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic               mul_iss;
    logic               short_iss;
    logic [MUL_LAT-2:0] mul_hist;
    logic               mul_due;

    assign mul_iss   = in_valid && (in_op[3:2] == 2'd2);
    assign short_iss = in_valid && (in_op[3:2] != 2'd2);
    assign mul_due   = mul_hist[MUL_LAT-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_hist <= '0;
        end else begin
            mul_hist[0] <= mul_iss;
            for (int i = 1; i <= MUL_LAT - 2; i++) begin
                mul_hist[i] <= mul_hist[i-1];
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R7
    short_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_iss && !mul_due) |=> out_valid);

    // R9
    mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_due |=> out_valid);

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!short_iss && !mul_due) |=> !out_valid);

    // R4
    plain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 6'b000000 && !mul_due)
        |=> out_data == $past(in_a + in_b));

    // R5
    rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 6'b000100 && in_b[4:0] == 5'd0 && !mul_due)
        |=> out_data == $past(in_a));

endmodule

bind cfu_fused_unit cfu_fused_unit_chk #(
    .DATA_W  (DATA_W),
    .MUL_LAT (MUL_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cfu_fused_unit_bench.sv
module cfu_fused_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [31:0] in_c = '0;
    logic        tbl_wr_en = 1'b0;
    logic [7:0]  tbl_wr_idx = '0;
    logic [31:0] tbl_wr_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [31:0] tbl_m [256];
    bit          slot_v [8];
    logic [31:0] slot_d [8];
    string       slot_t [8];

    always #10 clk = ~clk;   // 50 MHz

    cfu_fused_unit u_cfu_fused_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_c        (in_c),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_idx  (tbl_wr_idx),
        .tbl_wr_data (tbl_wr_data),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    function automatic logic [31:0] bop(logic [1:0] k, logic [31:0] x, logic [31:0] m);
        if (k == 2'd1) return x ^ m;
        if (k == 2'd2) return x & m;
        return x;   // R2: codes 0 and 3 pass
    endfunction

    function automatic logic [31:0] model(logic [5:0] op, logic [31:0] a,
                                          logic [31:0] b, logic [31:0] c);
        logic [31:0] p;
        logic [31:0] r;
        logic [4:0]  s;
        p = bop(op[1:0], a, c);            // R3
        s = b[4:0];
        case (op[3:2])
            2'd0: r = p + b;               // R4
            2'd1: r = (s == 0) ? p : ((p << s) | (p >> (32 - s)));  // R5
            2'd2: r = p * b;               // R9
            default: r = tbl_m[p[7:0]];    // R8
        endcase
        return bop(op[5:4], r, c);         // R6
    endfunction

    function automatic logic [31:0] tinit(int i);
        return (32'(i) * 32'h9E37_79B1) ^ {8'(i), 24'h00_0000};
    endfunction

    task automatic check_slot();
        int k;
        k = cyc % 8;
        n_checks++;
        if (slot_v[k]) begin
            if (out_valid !== 1'b1 || out_data !== slot_d[k]) begin
                n_fail++;
                $display("FAIL %s: cycle %0d got valid=%0b data=%h expected valid=1 data=%h",
                         slot_t[k], cyc, out_valid, out_data, slot_d[k]);
            end
        end else if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: cycle %0d got valid=%0b expected valid=0", cyc, out_valid);
        end
        slot_v[k] = 1'b0;
        slot_t[k] = "R11";
    endtask

    task automatic step(input bit v, input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c,
                        input bit we, input logic [7:0] widx, input logic [31:0] wdat);
        int k;
        string tag;
        @(negedge clk);
        check_slot();
        in_valid    = v;
        in_op       = op;
        in_a        = a;
        in_b        = b;
        in_c        = c;
        tbl_wr_en   = we;
        tbl_wr_idx  = widx;
        tbl_wr_data = wdat;
        if (v) begin
            case (op[3:2])
                2'd0: tag = "R4";
                2'd1: tag = "R5";
                2'd2: tag = "R9";
                default: tag = "R8";
            endcase
            if (op[3:2] != 2'd2 && (op[1:0] != 0 || op[5:4] != 0)) tag = "R6";
            k = (op[3:2] == 2'd2) ? (cyc + 3) % 8 : (cyc + 1) % 8;
            if (slot_v[k]) begin
                slot_t[k] = "R10";   // short op discarded, multiply keeps the slot
            end else begin
                slot_v[k] = 1'b1;
                slot_d[k] = model(op, a, b, c);
                slot_t[k] = (op[3:2] == 2'd2) ? tag : "R7";
                if (op[3:2] != 2'd2) slot_t[k] = tag;
            end
        end
        if (we) tbl_m[widx] = wdat;   // R8: same-cycle read saw the old word
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 6'h3F, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pa [4];
        logic [31:0] pb [4];
        logic [31:0] pc [4];
        pa[0] = 32'hFFFF_FFFF; pb[0] = 32'h0000_0001; pc[0] = 32'h0F0F_0F0F;
        pa[1] = 32'h8000_0000; pb[1] = 32'h8000_0000; pc[1] = 32'hFFFF_0000;
        pa[2] = 32'h1234_5678; pb[2] = 32'h9ABC_DEF0; pc[2] = 32'h00FF_00FF;
        pa[3] = 32'h0000_0000; pb[3] = 32'h0000_001F; pc[3] = 32'hAAAA_AAAA;
        for (int i = 0; i < 8; i++) begin
            slot_v[i] = 1'b0;
            slot_t[i] = "R11";
        end

        // R1: quiet during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: got valid=%0b expected valid=0", out_valid);
            end
        end
        rst_n = 1'b1;

        // R1 / R11: idle cycles with junk opcode and in_valid low
        idle(4);

        // R8: load every table entry
        for (int i = 0; i < 256; i++) step(0, 0, 0, 0, 0, 1, 8'(i), tinit(i));

        // R2 R3 R4 R5 R6 R7: every pre/core/post mix except multiply
        for (int pre = 0; pre < 4; pre++)
            for (int core = 0; core < 4; core++)
                for (int post = 0; post < 4; post++)
                    for (int p = 0; p < 4; p++)
                        if (core != 2)
                            step(1, {2'(post), 2'(core), 2'(pre)}, pa[p], pb[p], pc[p], 0, 0, 0);

        // R5: every rotate amount with junk in the upper bits of B
        for (int s = 0; s < 32; s++)
            step(1, 6'b000100, 32'hC001_D00D, {27'h5A5A5A5, 5'(s)}, 0, 0, 0, 0);

        // R8: read every entry via a XOR pre-op, junk above the index byte
        for (int i = 0; i < 256; i++)
            step(1, 6'b001101, {24'hABCDEF, 8'(i) ^ 8'h55}, 0, 32'h0000_0055, 0, 0, 0);

        // R8: write and read index 7 in one cycle, then read it again
        step(1, 6'b001100, 32'h7, 0, 0, 1, 8'd7, 32'hFEED_F00D);
        step(1, 6'b001100, 32'h7, 0, 0, 0, 0, 0);

        // R9: back-to-back multiplies with mixed Boolean steps
        for (int i = 0; i < 24; i++)
            step(1, {2'(i % 4), 2'd2, 2'((i / 4) % 4)}, 32'h1357_9BDF * 32'(i + 1),
                 32'hFFFF_FFFF - 32'(i * 977), pc[i % 4], 0, 0, 0);
        idle(3);

        // R9: a short op issued right after a multiply completes first
        step(1, 6'b001000, 32'h0001_0003, 32'h0002_0005, 0, 0, 0, 0);
        step(1, 6'b000000, 32'h0000_0010, 32'h0000_0020, 0, 0, 0, 0);
        idle(4);

        // R10: short op issued two cycles after a multiply is discarded
        step(1, 6'b011000, 32'h0000_0100, 32'h0000_0300, 32'h0000_FFFF, 0, 0, 0);
        idle(1);
        step(1, 6'b000000, 32'h1111_1111, 32'h2222_2222, 0, 0, 0, 0);
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule